// File: doc/BRIEF.md
# Manchester Transmit Encoder with Sync Preamble

This block turns a serial NRZ bit stream into Manchester II line code. It runs from a single system clock. A rate input sets each half-bit to 8 or 16 system clocks, so the bit rate is 1/16 or 1/32 of the system clock. A free-running bit clock output paces the external source that supplies the NRZ bits.

An active-low clear-to-send input gates the whole transmitter. While it is high, the two line outputs rest high and the bit clock rests low. Each time it is pulled low, the block sends a fixed preamble first: eight Manchester zeros, then a three-bit command sync (1.5 bits high, then 1.5 bits low). After that it encodes incoming NRZ bits back to back for as long as clear-to-send stays low. There is no framing and no parity.

The two line outputs are complementary while the block is active. The data on them is inverted with respect to the nominal encoding.

Top module: `mtx_encoder`

## Requirements
- R1: While `cts_n` is high, and from reset, `tx_pos` and `tx_neg` are both 1 and `bit_clk` is 0.
- R2: A half-bit lasts exactly 8 system clocks when `rate_slow` is 0 and exactly 16 when it is 1. The first half-bit starts at the first rising clock edge that samples `cts_n` low.
- R3: While the transmitter is active, `tx_neg` is always the complement of `tx_pos`.
- R4: The preamble is 16 half-bits. Each pair is nominal low then high, so on the pins `tx_pos` reads 1 then 0.
- R5: The command sync follows the preamble and lasts 6 half-bits. It is nominal high for 3 half-bits and then low for 3, so on the pins `tx_pos` reads 0,0,0,1,1,1.
- R6: `bit_clk` is 1 in the first half and 0 in the second half of every bit period, counted from the start of the preamble.
- R7: `nrz_in` is sampled at the clock edge where `bit_clk` falls. The first sample is taken in the last sync bit. A bit sampled in one bit period is sent in the next one.
- R8: Nominal data encoding is 1 as high-then-low and 0 as low-then-high. On the pins `tx_pos` carries the inverted level. Bits follow each other with no gaps.
- R9: If `cts_n` rises at any point, including mid-bit, the outputs are idle after the next rising clock edge. While `cts_n` stays high, `nrz_in` has no effect on any output.
- R10: Every falling edge of `cts_n` restarts transmission from the first half-bit of the preamble.
- R11: Between half-bit boundaries the line outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_slow | input | 1 | 1: half-bit of 16 clocks; 0: half-bit of 8 clocks |
| cts_n | input | 1 | Active-low clear-to-send |
| nrz_in | input | 1 | Serial NRZ data from the external source |
| bit_clk | output | 1 | Free-running bit clock; 0 while idle |
| tx_pos | output | 1 | Inverted Manchester line output; 1 while idle |
| tx_neg | output | 1 | Complement of `tx_pos` while active; 1 while idle |

## Verification
The hardest case to reach is a clear-to-send release in the middle of a bit, followed by a fresh start. The divider and the half-bit counter must both come back cleanly, and no leftover sample may leak into the new preamble. The bench releases `cts_n` halfway through a preamble half-bit and, in a separate run, halfway through a data half-bit. It toggles `nrz_in` while the block is idle, then pulls `cts_n` low again and checks every clock of the next full frame. During the preamble the bench also drives the complement of the first data bit. This exposes any sample taken before the sync.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_SYNC = 2'd2,
    ST_DATA = 2'd3
  } tx_state_e;

  localparam int unsigned SYNC_HALVES = 6;
  localparam int unsigned SYNC_HIGH   = 3;
endpackage

// File: rtl/mtx_rate_gen.sv
module mtx_rate_gen #(
  parameter int unsigned HALF_FAST = 8,
  parameter int unsigned HALF_SLOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rate_slow,
  output logic half_end
);
  localparam int unsigned CW = $clog2(HALF_SLOW + 1);

  logic [CW-1:0] cnt_q, cnt_d, last_cnt;

  always_comb begin
    last_cnt = rate_slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
    half_end = run && (cnt_q >= last_cnt);
    if (!run)          cnt_d = '0;
    else if (half_end) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF_SLOW));

  // R2
  half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |=> !half_end);
endmodule

// File: rtl/mtx_sequencer.sv
module mtx_sequencer
  import mtx_pkg::*;
#(
  parameter int unsigned PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic half_end,
  input  logic nrz_in,
  output logic run,
  output logic nominal,
  output logic bclk
);
  localparam int unsigned PRE_HALVES = 2 * PRE_BITS;
  localparam int unsigned HW = (PRE_HALVES > 8) ? $clog2(PRE_HALVES) : 3;

  tx_state_e st_q, st_d;
  logic [HW-1:0] h_q, h_d;
  logic samp_q, samp_d;
  logic cur_q, cur_d;

  always_comb begin
    st_d   = st_q;
    h_d    = h_q;
    samp_d = samp_q;
    cur_d  = cur_q;
    if (cts_n) begin
      st_d = ST_IDLE;
      h_d  = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d = ST_PRE;
          h_d  = '0;
        end
        ST_PRE: if (half_end) begin
          if (h_q == HW'(PRE_HALVES - 1)) begin
            st_d = ST_SYNC;
            h_d  = '0;
          end else begin
            h_d = h_q + HW'(1);
          end
        end
        ST_SYNC: if (half_end) begin
          if (h_q == HW'(SYNC_HALVES - 2)) samp_d = nrz_in;
          if (h_q == HW'(SYNC_HALVES - 1)) begin
            st_d  = ST_DATA;
            h_d   = '0;
            cur_d = samp_q;
          end else begin
            h_d = h_q + HW'(1);
          end
        end
        ST_DATA: if (half_end) begin
          if (!h_q[0]) begin
            samp_d = nrz_in;
            h_d    = HW'(1);
          end else begin
            cur_d = samp_q;
            h_d   = '0;
          end
        end
        default: begin
          st_d = ST_IDLE;
          h_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      h_q    <= '0;
      samp_q <= 1'b0;
      cur_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      h_q    <= h_d;
      samp_q <= samp_d;
      cur_q  <= cur_d;
    end
  end

  always_comb begin
    run  = (st_q != ST_IDLE);
    bclk = run && !h_q[0];
    case (st_q)
      ST_PRE:  nominal = h_q[0];
      ST_SYNC: nominal = (h_q < HW'(SYNC_HIGH));
      ST_DATA: nominal = cur_q ^ h_q[0];
      default: nominal = 1'b0;
    endcase
  end

  // R5
  sync_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC) |-> (h_q < HW'(SYNC_HALVES)));

  // R8
  data_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && half_end && h_q == HW'(SYNC_HALVES - 1) && !cts_n)
      |=> (st_q == ST_DATA && h_q == '0));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !cts_n) |=> (st_q == ST_PRE && h_q == '0));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_n |=> (st_q == ST_IDLE));
endmodule

// File: rtl/mtx_line_out.sv
module mtx_line_out #(
  parameter bit INVERT_LINE = 1'b1
) (
  input  logic run,
  input  logic nominal,
  input  logic bclk,
  output logic tx_pos,
  output logic tx_neg,
  output logic bit_clk
);
  logic level;

  always_comb begin
    level   = nominal ^ INVERT_LINE;
    tx_pos  = run ? level  : 1'b1;
    tx_neg  = run ? !level : 1'b1;
    bit_clk = run && bclk;
  end
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder #(
  parameter int unsigned HALF_FAST   = 8,
  parameter int unsigned HALF_SLOW   = 16,
  parameter int unsigned PRE_BITS    = 8,
  parameter bit          INVERT_LINE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_slow,
  input  logic cts_n,
  input  logic nrz_in,
  output logic bit_clk,
  output logic tx_pos,
  output logic tx_neg
);
  logic run, half_end, nominal, bclk;

  mtx_rate_gen #(
    .HALF_FAST(HALF_FAST),
    .HALF_SLOW(HALF_SLOW)
  ) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .rate_slow(rate_slow),
    .half_end (half_end)
  );

  mtx_sequencer #(
    .PRE_BITS(PRE_BITS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cts_n   (cts_n),
    .half_end(half_end),
    .nrz_in  (nrz_in),
    .run     (run),
    .nominal (nominal),
    .bclk    (bclk)
  );

  mtx_line_out #(
    .INVERT_LINE(INVERT_LINE)
  ) u_line (
    .run    (run),
    .nominal(nominal),
    .bclk   (bclk),
    .tx_pos (tx_pos),
    .tx_neg (tx_neg),
    .bit_clk(bit_clk)
  );

  // R1
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cts_n) |-> (tx_pos && tx_neg && !bit_clk));

  // R3
  compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tx_pos ^ tx_neg));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(half_end)) |-> $stable(tx_pos));
endmodule

// File: tb/mtx_encoder_bench.sv
`timescale 1ns/1ps
module mtx_encoder_bench;
  logic clk = 1'b0;
  logic rst_n, rate_slow, cts_n, nrz_in;
  logic bit_clk, tx_pos, tx_neg;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mtx_encoder u_mtx_encoder (
    .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .cts_n(cts_n),
    .nrz_in(nrz_in), .bit_clk(bit_clk), .tx_pos(tx_pos), .tx_neg(tx_neg)
  );

  function automatic bit pat(input int seed, input int n);
    case (seed)
      0: return n[0];
      1: return 1'b1;
      2: return 1'b0;
      default: return ((n * 5 + 3) % 7) < 3;
    endcase
  endfunction

  function automatic bit exp_nom(input int h, input int seed);
    if (h < 16) return h[0];
    if (h < 22) return (h - 16) < 3;
    if (h[0] == 1'b0) return pat(seed, (h - 22) / 2);
    return !pat(seed, (h - 22) / 2);
  endfunction

  function automatic string tag_of(input int h);
    if (h < 16) return "R2 R3 R4 R6";
    if (h < 22) return "R2 R3 R5 R6";
    return "R2 R3 R6 R7 R8";
  endfunction

  task automatic check_idle(input string tag);
    checks++;
    if (!(tx_pos === 1'b1 && tx_neg === 1'b1 && bit_clk === 1'b0)) begin
      errors++;
      $display("FAIL %s idle: pos=%b neg=%b clk=%b expected pos=1 neg=1 clk=0",
               tag, tx_pos, tx_neg, bit_clk);
    end
  endtask

  // Runs halves 0..halves-1 of one frame; abort_cyc >= 0 releases cts_n at that cycle.
  task automatic run_frame(input bit slow, input int seed, input int halves, input int abort_cyc);
    int hl;
    bit bad;
    logic [2:0] act, expv;
    hl = slow ? 16 : 8;
    rate_slow = slow;
    @(negedge clk);
    cts_n = 1'b0;
    nrz_in = !pat(seed, 0);
    @(posedge clk);
    bad = 1'b0;
    act = '0;
    expv = '0;
    for (int i = 0; i < halves * hl; i++) begin
      int h;
      bit nom;
      @(negedge clk);
      h = i / hl;
      nom = exp_nom(h, seed);
      if (!bad && {tx_pos, tx_neg, bit_clk} !== {!nom, nom, !h[0]}) begin
        bad = 1'b1;
        act = {tx_pos, tx_neg, bit_clk};
        expv = {!nom, nom, !h[0]};
      end
      nrz_in = (h < 19) ? !pat(seed, 0) : pat(seed, (h - 19) / 2);
      if (i % hl == hl - 1 || i == abort_cyc) begin
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s half %0d rate %0d: {pos,neg,clk}=%b expected %b",
                   tag_of(h), h, slow, act, expv);
        end
        bad = 1'b0;
      end
      if (i == abort_cyc) break;
    end
    cts_n = 1'b1;
    @(negedge clk);
    check_idle("R1 R9");
    for (int k = 0; k < 20; k++) begin
      nrz_in = k[0];
      @(negedge clk);
      if (k == 19) check_idle("R9");
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cts_n = 1'b1;
    rate_slow = 1'b0;
    nrz_in = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) run_frame(r[0], s, 22 + 2 * 12, -1);
      // R9 abort mid preamble half, then R10 restart
      run_frame(r[0], 3, 22 + 2 * 12, (r[0] ? 16 : 8) * 5 + 3);
      run_frame(r[0], 0, 22 + 2 * 12, -1);
      // R9 abort mid data half, then R10 restart
      run_frame(r[0], 3, 22 + 2 * 12, (r[0] ? 16 : 8) * 27 + 4);
      run_frame(r[0], 3, 22 + 2 * 12, -1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule